// File: doc/BRIEF.md
# Cartridge Mapper with Banked Save RAM

This block is the address-banking core of a game cartridge mapper whose registers are loaded one bit per CPU write. The CPU writes into the $8000-$FFFF range; each write feeds one data bit into a five-bit serial loader. The fifth write commits the assembled value to one of four registers: control, CHR page A, CHR page B or PRG bank. From those registers the block forms the PRG ROM address for CPU reads, the CHR RAM address for PPU accesses and the nametable select bit for the chosen mirroring. It also forms the address and the chip selects for two 8 KB work-RAM chips that sit at CPU $6000-$7FFF.

CHR memory here is a fixed 8 KB RAM. Bit 3 of each CHR page register is therefore free, and it selects which work-RAM chip answers: 0 picks the volatile chip and 1 picks the battery-backed chip. In whole-8 KB CHR mode only page register A supplies that bit. In split 4 KB mode, PPU address bit 12 decides which page register is in effect, so the RAM chip choice can flip while the PPU renders.

The serial loader is a two-state machine. LD_IDLE means the shift register is empty. LD_FILL means one to four bits have been collected. Transitions: IDLE to FILL on a normal write; FILL to FILL while fewer than four bits are held; FILL to IDLE on the fifth write (commit); any state to IDLE on a write with data bit 7 set (abort).

Top module: `cart_mapper_banked_wram`

## Requirements
- R1: A register write commits only on the fifth consecutive data-bit-7-clear write to $8000-$FFFF. The value is taken LSB first, from data bit 0 of each write. Address bits 14:13 of the fifth write select the target: 00 control, 01 CHR page A, 10 CHR page B, 11 PRG bank. Fewer than five writes change no output.
- R2: A write with data bit 7 set empties the loader and sets control bits 3:2 to 11. Control bits 1:0 and bit 4 stay unchanged.
- R3: Reset sets control to 5'b01100 and the other registers to zero.
- R4: With control bits 3:2 equal to 00 or 01 (32 KB mode), the PRG ROM address is {prg[3:1], cpu_addr[14], cpu_addr[13:0]}.
- R5: With control bits 3:2 equal to 10, $8000-$BFFF maps to bank 0 and $C000-$FFFF maps to bank prg[3:0]. The address is {bank, cpu_addr[13:0]}.
- R6: With control bits 3:2 equal to 11, $8000-$BFFF maps to bank prg[3:0] and $C000-$FFFF maps to bank 4'hF.
- R7: The active-low work-RAM selects wram_cs_n[1:0] are both high outside $6000-$7FFF. Inside that window, exactly bit k is low, where k is the current RAM bank bit. wram_addr is cpu_addr[12:0].
- R8: With control bit 4 equal to 0 (8 KB CHR), the RAM bank bit is bit 3 of page A, whatever ppu_addr[12] and page B hold.
- R9: With control bit 4 equal to 1 (4 KB CHR), the RAM bank bit is bit 3 of page A when ppu_addr[12]=0 and bit 3 of page B when ppu_addr[12]=1.
- R10: In 8 KB CHR mode, chr_ram_addr equals ppu_addr[12:0]. In 4 KB mode, bit 12 is bit 0 of page A (when ppu_addr[12]=0) or of page B (when ppu_addr[12]=1), and bits 11:0 are ppu_addr[11:0].
- R11: nt_sel follows control bits 1:0: 00 gives 0, 01 gives 1, 10 gives ppu_addr[10], 11 gives ppu_addr[11].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata_lsb | input | 1 | CPU write data bit 0 (serial bit) |
| cpu_wdata_msb | input | 1 | CPU write data bit 7 (loader abort) |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| ppu_addr | input | 13 | PPU pattern address bits 12:0 |
| prg_rom_addr | output | 18 | Banked PRG ROM address |
| wram_addr | output | 13 | Work-RAM address within a chip |
| wram_cs_n | output | 2 | Active-low work-RAM chip selects |
| chr_ram_addr | output | 13 | CHR RAM address |
| nt_sel | output | 1 | Nametable select bit |

## Verification
The bench's central case is 4 KB CHR mode with the two page registers holding different RAM bits. Toggling ppu_addr[12] must then move the low select from one chip to the other; a design that ignored A12 would leave one chip selected. In 8 KB mode page B is loaded with the opposite RAM bit and CHR bit, and A12 is swept. A design that consulted page B there would switch chips or CHR halves. The bench also aborts a partial load with a bit-7 write and then loads a full value. A loader that kept stale bits would commit early or commit a shifted value. Finally, each PRG mode is read at both halves of the ROM window; a swapped fixed bank or a missing A14 in 32 KB mode shows up as a wrong ROM address.

// File: rtl/cmap_pkg.sv
`timescale 1ns/1ps
package cmap_pkg;
    localparam int REG_W      = 5;
    localparam int PRG_BANK_W = 4;
    localparam int PRG_PAGE_W = 14;
    localparam int CHR_AW     = 13;
    localparam int WRAM_AW    = 13;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'b00,
        SEL_PAGEA = 2'b01,
        SEL_PAGEB = 2'b10,
        SEL_PRG   = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        MIR_LOW   = 2'b00,
        MIR_HIGH  = 2'b01,
        MIR_VERT  = 2'b10,
        MIR_HORIZ = 2'b11
    } mirror_e;

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_FILL = 1'b1
    } ld_state_e;

    localparam logic [REG_W-1:0] CTRL_RESET = 5'b01100;
endpackage

// File: rtl/cmap_serial_loader.sv
`timescale 1ns/1ps
module cmap_serial_loader
    import cmap_pkg::*;
#(
    parameter int WIDTH = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             bit_in,
    input  logic             abort,
    output logic             commit_vld,
    output logic [WIDTH-1:0] commit_val,
    output logic             clear_req
);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    ld_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [WIDTH-1:0] shift_q, shift_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        shift_d = shift_q;
        if (wr_en && abort) begin
            state_d = LD_IDLE;
            cnt_d   = '0;
            shift_d = '0;
        end else if (wr_en) begin
            unique case (state_q)
                LD_IDLE: begin
                    state_d = LD_FILL;
                    cnt_d   = CNT_W'(1);
                    shift_d = {bit_in, shift_q[WIDTH-1:1]};
                end
                LD_FILL: begin
                    if (cnt_q == LAST) begin
                        state_d = LD_IDLE;
                        cnt_d   = '0;
                        shift_d = '0;
                    end else begin
                        cnt_d   = cnt_q + CNT_W'(1);
                        shift_d = {bit_in, shift_q[WIDTH-1:1]};
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shift_q <= shift_d;
        end
    end

    always_comb begin
        clear_req  = wr_en && abort;
        commit_vld = wr_en && !abort && (state_q == LD_FILL) && (cnt_q == LAST);
        commit_val = {bit_in, shift_q[WIDTH-1:1]};
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R1
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_IDLE) |-> (cnt_q == '0 && shift_q == '0)); // R1
endmodule

// File: rtl/cmap_regs.sv
`timescale 1ns/1ps
module cmap_regs
    import cmap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_vld,
    input  logic [REG_W-1:0]      commit_val,
    input  reg_sel_e              commit_sel,
    input  logic                  clear_req,
    output logic [REG_W-1:0]      ctrl,
    output logic                  pga_chr,
    output logic                  pga_ram,
    output logic                  pgb_chr,
    output logic                  pgb_ram,
    output logic [PRG_BANK_W-1:0] prg_bank
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= CTRL_RESET;
            pga_chr  <= 1'b0;
            pga_ram  <= 1'b0;
            pgb_chr  <= 1'b0;
            pgb_ram  <= 1'b0;
            prg_bank <= '0;
        end else if (clear_req) begin
            ctrl[3:2] <= 2'b11;
        end else if (commit_vld) begin
            unique case (commit_sel)
                SEL_CTRL:  ctrl <= commit_val;
                SEL_PAGEA: begin
                    pga_chr <= commit_val[0];
                    pga_ram <= commit_val[3];
                end
                SEL_PAGEB: begin
                    pgb_chr <= commit_val[0];
                    pgb_ram <= commit_val[3];
                end
                SEL_PRG:   prg_bank <= commit_val[PRG_BANK_W-1:0];
            endcase
        end
    end

    AST_ABORT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (ctrl[3:2] == 2'b11)); // R2
    AST_ABORT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (ctrl[1:0] == $past(ctrl[1:0]) && ctrl[4] == $past(ctrl[4]))); // R2
endmodule

// File: rtl/cmap_bank_logic.sv
`timescale 1ns/1ps
module cmap_bank_logic
    import cmap_pkg::*;
#(
    localparam int PRG_AW = PRG_BANK_W + PRG_PAGE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           cpu_addr,
    input  logic [12:0]           ppu_addr,
    input  logic [REG_W-1:0]      ctrl,
    input  logic                  pga_chr,
    input  logic                  pga_ram,
    input  logic                  pgb_chr,
    input  logic                  pgb_ram,
    input  logic [PRG_BANK_W-1:0] prg_bank,
    output logic [PRG_AW-1:0]     prg_rom_addr,
    output logic [WRAM_AW-1:0]    wram_addr,
    output logic [1:0]            wram_cs_n,
    output logic [CHR_AW-1:0]     chr_ram_addr,
    output logic                  nt_sel
);
    logic                  chr_split, use_b, ram_bit, chr_bit, in_win;
    logic [PRG_BANK_W-1:0] bank;
    mirror_e               mir;

    always_comb begin
        chr_split = ctrl[4];
        use_b     = chr_split && ppu_addr[12];
        ram_bit   = use_b ? pgb_ram : pga_ram;
        chr_bit   = !chr_split ? ppu_addr[12] : (use_b ? pgb_chr : pga_chr);
        in_win    = (cpu_addr[15:13] == 3'b011);

        unique case (ctrl[3:2])
            2'b00, 2'b01: bank = {prg_bank[PRG_BANK_W-1:1], cpu_addr[14]};
            2'b10:        bank = cpu_addr[14] ? prg_bank : '0;
            2'b11:        bank = cpu_addr[14] ? '1 : prg_bank;
        endcase
        prg_rom_addr = {bank, cpu_addr[PRG_PAGE_W-1:0]};

        wram_addr = cpu_addr[WRAM_AW-1:0];
        wram_cs_n = 2'b11;
        if (in_win) wram_cs_n[ram_bit] = 1'b0;

        chr_ram_addr = {chr_bit, ppu_addr[11:0]};

        mir = mirror_e'(ctrl[1:0]);
        unique case (mir)
            MIR_LOW:   nt_sel = 1'b0;
            MIR_HIGH:  nt_sel = 1'b1;
            MIR_VERT:  nt_sel = ppu_addr[10];
            MIR_HORIZ: nt_sel = ppu_addr[11];
        endcase
    end

    AST_CS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~wram_cs_n)); // R7
    AST_CS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] != 3'b011) |-> (wram_cs_n == 2'b11)); // R7
    AST_CS_FIXED_8K: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[4] && $past(!ctrl[4]) && $stable(pga_ram) && $stable(cpu_addr[15:13]))
        |-> $stable(wram_cs_n)); // R8
endmodule

// File: rtl/cart_mapper_banked_wram.sv
`timescale 1ns/1ps
module cart_mapper_banked_wram
    import cmap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_wdata_lsb,
    input  logic        cpu_wdata_msb,
    input  logic        cpu_wr,
    input  logic [12:0] ppu_addr,
    output logic [17:0] prg_rom_addr,
    output logic [12:0] wram_addr,
    output logic [1:0]  wram_cs_n,
    output logic [12:0] chr_ram_addr,
    output logic        nt_sel
);
    logic                  reg_wr, commit_vld, clear_req;
    logic [REG_W-1:0]      commit_val, ctrl;
    logic                  pga_chr, pga_ram, pgb_chr, pgb_ram;
    logic [PRG_BANK_W-1:0] prg_bank;
    reg_sel_e              commit_sel;

    assign reg_wr     = cpu_wr && cpu_addr[15];
    assign commit_sel = reg_sel_e'(cpu_addr[14:13]);

    cmap_serial_loader #(.WIDTH(REG_W)) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .bit_in     (cpu_wdata_lsb),
        .abort      (cpu_wdata_msb),
        .commit_vld (commit_vld),
        .commit_val (commit_val),
        .clear_req  (clear_req)
    );

    cmap_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_vld (commit_vld),
        .commit_val (commit_val),
        .commit_sel (commit_sel),
        .clear_req  (clear_req),
        .ctrl       (ctrl),
        .pga_chr    (pga_chr),
        .pga_ram    (pga_ram),
        .pgb_chr    (pgb_chr),
        .pgb_ram    (pgb_ram),
        .prg_bank   (prg_bank)
    );

    cmap_bank_logic u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_addr     (cpu_addr),
        .ppu_addr     (ppu_addr),
        .ctrl         (ctrl),
        .pga_chr      (pga_chr),
        .pga_ram      (pga_ram),
        .pgb_chr      (pgb_chr),
        .pgb_ram      (pgb_ram),
        .prg_bank     (prg_bank),
        .prg_rom_addr (prg_rom_addr),
        .wram_addr    (wram_addr),
        .wram_cs_n    (wram_cs_n),
        .chr_ram_addr (chr_ram_addr),
        .nt_sel       (nt_sel)
    );
endmodule

// File: tb/cart_mapper_banked_wram_tb.sv
`timescale 1ns/1ps
module cart_mapper_banked_wram_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_wdata_lsb = 1'b0;
    logic        cpu_wdata_msb = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [12:0] ppu_addr = 13'h0000;
    logic [17:0] prg_rom_addr;
    logic [12:0] wram_addr;
    logic [1:0]  wram_cs_n;
    logic [12:0] chr_ram_addr;
    logic        nt_sel;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cart_mapper_banked_wram u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_addr      (cpu_addr),
        .cpu_wdata_lsb (cpu_wdata_lsb),
        .cpu_wdata_msb (cpu_wdata_msb),
        .cpu_wr        (cpu_wr),
        .ppu_addr      (ppu_addr),
        .prg_rom_addr  (prg_rom_addr),
        .wram_addr     (wram_addr),
        .wram_cs_n     (wram_cs_n),
        .chr_ram_addr  (chr_ram_addr),
        .nt_sel        (nt_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic d0, input logic d7);
        @(negedge clk);
        cpu_addr = a; cpu_wdata_lsb = d0; cpu_wdata_msb = d7; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_wdata_msb = 1'b0;
    endtask

    task automatic load_reg(input logic [15:0] a, input logic [4:0] v);
        for (int i = 0; i < 5; i++) cpu_write(a, v[i], 1'b0);
    endtask

    task automatic probe_cpu(input logic [15:0] a);
        cpu_addr = a;
        #1;
    endtask

    task automatic probe_ppu(input logic [12:0] p);
        ppu_addr = p;
        #1;
    endtask

    task automatic t_reset;
        probe_cpu(16'hC000); check("R3 fixed last bank", 32'(prg_rom_addr), 32'h3C000);
        probe_cpu(16'h8000); check("R3 prg bank zero", 32'(prg_rom_addr), 32'h00000);
        probe_cpu(16'h6000); check("R3 volatile chip", 32'(wram_cs_n), 32'h2);
        probe_ppu(13'h0C00); check("R3 mirror low", 32'(nt_sel), 32'h0);
    endtask

    task automatic t_serial;
        for (int i = 0; i < 4; i++) cpu_write(16'hE000, (i == 0) || (i == 2), 1'b0);
        probe_cpu(16'h8000); check("R1 partial no commit", 32'(prg_rom_addr), 32'h00000);
        cpu_write(16'hE000, 1'b0, 1'b0);
        probe_cpu(16'h8000); check("R1 fifth write commits", 32'(prg_rom_addr), 32'h14000);
    endtask

    task automatic t_abort;
        load_reg(16'h8000, 5'b00000);
        probe_cpu(16'hC000); check("R4 32KB upper half", 32'(prg_rom_addr), 32'h14000);
        cpu_write(16'hE000, 1'b1, 1'b0);
        cpu_write(16'hE000, 1'b1, 1'b0);
        cpu_write(16'hE000, 1'b0, 1'b1);
        probe_cpu(16'hC000); check("R2 abort forces last fixed", 32'(prg_rom_addr), 32'h3C000);
        probe_ppu(13'h0C00); check("R2 mirror kept", 32'(nt_sel), 32'h0);
        load_reg(16'hE000, 5'b00010);
        probe_cpu(16'h8000); check("R2 loader emptied", 32'(prg_rom_addr), 32'h08000);
        load_reg(16'hE000, 5'b00101);
    endtask

    task automatic t_prg_modes;
        load_reg(16'h8000, 5'b00100);
        probe_cpu(16'h8000); check("R4 32KB lower", 32'(prg_rom_addr), 32'h10000);
        probe_cpu(16'hC123); check("R4 32KB upper", 32'(prg_rom_addr), 32'h14123);
        load_reg(16'h8000, 5'b01000);
        probe_cpu(16'h8456); check("R5 lower fixed zero", 32'(prg_rom_addr), 32'h00456);
        probe_cpu(16'hC000); check("R5 upper switched", 32'(prg_rom_addr), 32'h14000);
        load_reg(16'h8000, 5'b01100);
        probe_cpu(16'h8000); check("R6 lower switched", 32'(prg_rom_addr), 32'h14000);
        probe_cpu(16'hFFFF); check("R6 upper fixed", 32'(prg_rom_addr), 32'h3FFFF);
    endtask

    task automatic t_8k;
        load_reg(16'h8000, 5'b01100);
        load_reg(16'hA000, 5'b01001);
        load_reg(16'hC000, 5'b00000);
        probe_cpu(16'h7ABC);
        check("R7 ram addr", 32'(wram_addr), 32'h1ABC);
        probe_ppu(13'h0123); check("R8 A12 low battery chip", 32'(wram_cs_n), 32'h1);
        check("R10 8KB chr low", 32'(chr_ram_addr), 32'h0123);
        probe_ppu(13'h1123); check("R8 A12 high battery chip", 32'(wram_cs_n), 32'h1);
        check("R10 8KB chr high", 32'(chr_ram_addr), 32'h1123);
        probe_cpu(16'h5FFF); check("R7 below window", 32'(wram_cs_n), 32'h3);
        probe_cpu(16'h8000); check("R7 above window", 32'(wram_cs_n), 32'h3);
    endtask

    task automatic t_4k;
        load_reg(16'h8000, 5'b11100);
        load_reg(16'hA000, 5'b01001);
        load_reg(16'hC000, 5'b00000);
        probe_cpu(16'h6000);
        probe_ppu(13'h0456); check("R9 A12 low page A", 32'(wram_cs_n), 32'h1);
        check("R10 4KB page A", 32'(chr_ram_addr), 32'h1456);
        probe_ppu(13'h1456); check("R9 A12 high page B", 32'(wram_cs_n), 32'h2);
        check("R10 4KB page B", 32'(chr_ram_addr), 32'h0456);
        probe_ppu(13'h0456); check("R9 back to page A", 32'(wram_cs_n), 32'h1);
    endtask

    task automatic t_mirror;
        for (int m = 0; m < 4; m++) begin
            load_reg(16'h8000, 5'(12 + m));
            probe_ppu(13'h0400);
            check("R11 mirror A10 set", 32'(nt_sel), (m == 1 || m == 2) ? 32'h1 : 32'h0);
            probe_ppu(13'h0800);
            check("R11 mirror A11 set", 32'(nt_sel), (m == 1 || m == 3) ? 32'h1 : 32'h0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_serial;
        t_abort;
        t_prg_modes;
        t_8k;
        t_4k;
        t_mirror;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule